// File: doc/BRIEF.md
# Power-Good Delay Generator

This block produces the power-good level for a supply supervisor. It asserts power-good only after every qualifying input has stayed good for a long, uninterrupted interval. The qualifying inputs are a line-good comparator flag, an under-voltage sense flag for each monitored rail, a fault-latched flag and an on-request input. Any break in qualification restarts that interval from zero.

Deassertion is fast, and each cause has its own filter. A latched fault or a withdrawn on-request pulls power-good low within the same cycle. A drop of the line-good flag must persist for a short deglitch window before it takes effect. Rail under-voltage sense must persist for a somewhat longer debounce window. Short dips on either input never clear an asserted power-good.

All intervals are parameters counted in clock cycles. With a 1 MHz clock, the defaults give 300 ms for qualification, 350 µs for the line deglitch and 1 ms for the rail debounce.

Top module: `pwrgood_delay`

## Requirements
- R1: While reset is held and on the first cycle after it, `pwr_good` is 0.
- R2: When all qualifying conditions are sampled true on QUAL_CYCLES consecutive clock edges, `pwr_good` becomes 1 right after the last of those edges. It is never 1 earlier. Qualifying means `line_ok`=1, every `uv_sense` bit 0, `fault_latched`=0 and `on_req`=1.
- R3: If qualification is missing on any one edge while `pwr_good` is low, the count restarts. A further QUAL_CYCLES consecutive qualifying edges are then needed.
- R4: While `pwr_good` is 1, `line_ok` low on fewer than LINE_FILT_CYCLES consecutive edges leaves `pwr_good` at 1.
- R5: When `line_ok` is sampled low on LINE_FILT_CYCLES consecutive edges, `pwr_good` is 0 right after the last of them.
- R6: While `pwr_good` is 1, a `uv_sense` bit high on fewer than UV_FILT_CYCLES consecutive edges leaves `pwr_good` at 1.
- R7: When any single `uv_sense` bit (bit 0 or bit 1) is sampled high on UV_FILT_CYCLES consecutive edges, `pwr_good` is 0 right after the last of them.
- R8: Whenever `fault_latched` is 1, `pwr_good` is 0 in that same cycle, without waiting for a clock edge.
- R9: Whenever `on_req` is 0, `pwr_good` is 0 in that same cycle.
- R10: After any drop, `pwr_good` returns to 1 only after a new full run of QUAL_CYCLES qualifying edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_ok | input | 1 | Line-good comparator flag, 1 = input line healthy |
| uv_sense | input | NUM_RAILS | Per-rail under-voltage sense flags, 1 = rail sagging |
| fault_latched | input | 1 | Protection fault is latched |
| on_req | input | 1 | Supply on-request, 1 = on requested |
| pwr_good | output | 1 | Power-good level |

## Verification
The assertion delay is tried in four ways: from reset, after each kind of drop, and with a qualification run broken by one missing cycle, either of `on_req` or of `line_ok`. Together these show whether the delay counts consecutive edges or accumulates them. Line and rail dips one cycle shorter than their windows are followed by dips of exactly the window length. This pins each filter length at its edge and tells apart the line and rail filter settings. Both rails are tripped separately to show that neither is ignored. `fault_latched` and `on_req` are also checked between clock edges, which separates a combinational gate from a registered clear.

// File: rtl/pwrgood_delay.sv
module pwrgood_delay #(
  parameter int QUAL_CYCLES      = 300000,
  parameter int LINE_FILT_CYCLES = 350,
  parameter int UV_FILT_CYCLES   = 1000,
  parameter int NUM_RAILS        = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line_ok,
  input  logic [NUM_RAILS-1:0] uv_sense,
  input  logic                 fault_latched,
  input  logic                 on_req,
  output logic                 pwr_good
);

  localparam int QW = $clog2(QUAL_CYCLES + 1);
  localparam int LW = $clog2(LINE_FILT_CYCLES + 1);
  localparam int UW = $clog2(UV_FILT_CYCLES + 1);
  localparam logic [QW-1:0] Q_LAST = QW'(QUAL_CYCLES - 1);
  localparam logic [LW-1:0] L_LAST = LW'(LINE_FILT_CYCLES - 1);
  localparam logic [UW-1:0] U_LAST = UW'(UV_FILT_CYCLES - 1);

  logic                 qualify;
  logic [QW-1:0]        qual_cnt;
  logic                 qual_done;
  logic [LW-1:0]        line_cnt;
  logic                 line_trip;
  logic [NUM_RAILS-1:0] uv_trip;
  logic                 force_low;
  logic                 pg_q;

  assign qualify   = line_ok & ~|uv_sense & ~fault_latched & on_req;
  assign qual_done = qualify & (qual_cnt >= Q_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              qual_cnt <= '0;
    else if (!qualify)       qual_cnt <= '0;
    else if (qual_cnt < Q_LAST) qual_cnt <= qual_cnt + 1'b1;
  end

  assign line_trip = ~line_ok & (line_cnt >= L_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              line_cnt <= '0;
    else if (line_ok)        line_cnt <= '0;
    else if (line_cnt < L_LAST) line_cnt <= line_cnt + 1'b1;
  end

  for (genvar r = 0; r < NUM_RAILS; r++) begin : g_rail
    logic [UW-1:0] uv_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             uv_cnt <= '0;
      else if (!uv_sense[r])  uv_cnt <= '0;
      else if (uv_cnt < U_LAST) uv_cnt <= uv_cnt + 1'b1;
    end

    assign uv_trip[r] = uv_sense[r] & (uv_cnt >= U_LAST);
  end

  assign force_low = fault_latched | ~on_req | line_trip | (|uv_trip);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pg_q <= 1'b0;
    else if (force_low) pg_q <= 1'b0;
    else if (qual_done) pg_q <= 1'b1;
  end

  assign pwr_good = pg_q & on_req & ~fault_latched;

endmodule

// File: rtl/pwrgood_delay_chk.sv
module pwrgood_delay_chk #(
  parameter int QUAL_CYCLES      = 300000,
  parameter int LINE_FILT_CYCLES = 350,
  parameter int UV_FILT_CYCLES   = 1000,
  parameter int NUM_RAILS        = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 line_ok,
  input logic [NUM_RAILS-1:0] uv_sense,
  input logic                 fault_latched,
  input logic                 on_req,
  input logic                 pwr_good
);

  int unsigned qrun;
  int unsigned lrun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) qrun <= 0;
    else if (!(line_ok && uv_sense == '0 && !fault_latched && on_req)) qrun <= 0;
    else if (qrun < QUAL_CYCLES) qrun <= qrun + 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lrun <= 0;
    else if (line_ok) lrun <= 0;
    else if (lrun < LINE_FILT_CYCLES) lrun <= lrun + 1;
  end

  assert_rise_qualified_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_good) |-> qrun >= QUAL_CYCLES);

  assert_line_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lrun >= LINE_FILT_CYCLES |-> !pwr_good);

  assert_fault_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_latched |-> !pwr_good);

  assert_onreq_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !on_req |-> !pwr_good);

  for (genvar r = 0; r < NUM_RAILS; r++) begin : g_uvchk
    int unsigned urun;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) urun <= 0;
      else if (!uv_sense[r]) urun <= 0;
      else if (urun < UV_FILT_CYCLES) urun <= urun + 1;
    end

    assert_uv_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      urun >= UV_FILT_CYCLES |-> !pwr_good);
  end

endmodule

bind pwrgood_delay pwrgood_delay_chk #(
  .QUAL_CYCLES(QUAL_CYCLES), .LINE_FILT_CYCLES(LINE_FILT_CYCLES),
  .UV_FILT_CYCLES(UV_FILT_CYCLES), .NUM_RAILS(NUM_RAILS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .line_ok(line_ok), .uv_sense(uv_sense),
  .fault_latched(fault_latched), .on_req(on_req), .pwr_good(pwr_good)
);

// File: tb/pwrgood_delay_bench.sv
module pwrgood_delay_bench;
  localparam int Q = 20;
  localparam int L = 4;
  localparam int U = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_ok = 1'b1;
  logic [1:0] uv_sense = 2'b00;
  logic       fault_latched = 1'b0;
  logic       on_req = 1'b1;
  logic       pwr_good;

  int checks = 0;
  int fails = 0;
  bit    exp_q[$];
  string tag_q[$];
  bit    done = 1'b0;

  always #5 clk = ~clk;

  pwrgood_delay #(.QUAL_CYCLES(Q), .LINE_FILT_CYCLES(L), .UV_FILT_CYCLES(U), .NUM_RAILS(2))
    u_pwrgood_delay (.clk(clk), .rst_n(rst_n), .line_ok(line_ok), .uv_sense(uv_sense),
                     .fault_latched(fault_latched), .on_req(on_req), .pwr_good(pwr_good));

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        bit    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (pwr_good !== e) begin
          fails++;
          $display("FAIL %s: pwr_good=%b expected %b at %0t", t, pwr_good, e, $time);
        end
      end
    end
  end

  task automatic step(input bit lo, input bit [1:0] uv, input bit flt, input bit on,
                      input bit e, input string t);
    @(negedge clk);
    line_ok = lo; uv_sense = uv; fault_latched = flt; on_req = on;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic qualify_run(input int n, input int rise_at, input string t);
    for (int i = 0; i < n; i++) step(1, 2'b00, 0, 1, (rise_at >= 0 && i >= rise_at), t);
  endtask

  task automatic direct_check(input bit e, input string t);
    #1;
    checks++;
    if (pwr_good !== e) begin
      fails++;
      $display("FAIL %s: pwr_good=%b expected %b at %0t", t, pwr_good, e, $time);
    end
  endtask

  initial begin
    for (int i = 0; i < 3; i++) step(1, 2'b00, 0, 1, 0, "R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    exp_q.push_back(0); tag_q.push_back("R1 first cycle");
    qualify_run(Q - 1, Q - 2, "R2 power-up delay");
    qualify_run(3, 0, "R2 held");
    for (int i = 0; i < L - 1; i++) step(0, 2'b00, 0, 1, 1, "R4 short line dip");
    qualify_run(3, 0, "R4 after dip");
    for (int i = 0; i < L; i++) step(0, 2'b00, 0, 1, (i < L - 1), "R5 line loss");
    qualify_run(Q, Q - 1, "R10 requalify after line loss");
    for (int i = 0; i < U - 1; i++) step(1, 2'b01, 0, 1, 1, "R6 short sag rail0");
    step(1, 2'b00, 0, 1, 1, "R6 gap");
    for (int i = 0; i < U - 1; i++) step(1, 2'b10, 0, 1, 1, "R6 short sag rail1");
    step(1, 2'b00, 0, 1, 1, "R6 gap");
    for (int i = 0; i < U; i++) step(1, 2'b10, 0, 1, (i < U - 1), "R7 sag rail1");
    qualify_run(Q, Q - 1, "R10 requalify after rail1 sag");
    for (int i = 0; i < U; i++) step(1, 2'b01, 0, 1, (i < U - 1), "R7 sag rail0");
    qualify_run(Q / 2, -1, "R3 partial run");
    step(1, 2'b00, 0, 0, 0, "R3 on_req break");
    qualify_run(Q, Q - 1, "R3 restart after on_req break");
    @(negedge clk); fault_latched = 1'b1;
    direct_check(0, "R8 immediate on fault");
    exp_q.push_back(0); tag_q.push_back("R8 fault edge");
    step(1, 2'b00, 0, 1, 0, "R10 no recovery after fault");
    qualify_run(Q - 1, Q - 2, "R10 requalify after fault");
    @(negedge clk); on_req = 1'b0;
    direct_check(0, "R9 immediate on request off");
    exp_q.push_back(0); tag_q.push_back("R9 request off edge");
    qualify_run(Q - 2, -1, "R3 partial before line break");
    step(0, 2'b00, 0, 1, 0, "R3 line break");
    qualify_run(Q, Q - 1, "R3 restart after line break");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule